// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Shifter

This block holds a parallel word in a staging register and passes it to a shift register that sends it out one bit at a time. The staging register and the shift register each respond to their own external rising-edge strobe. The shift register can also take a serial bit stream, and it has an active-low clear and an active-low parallel load. The load works only while the shift strobe sits low. While the shift strobe is high the load is held off. The load's data comes from the staging register, not from the data pins.

Every external pin is sampled by one fast system clock. The pins pass through two-flop synchronizers, and rising edges of the two strobes are detected in that clock domain. All register updates are synchronous to the system clock. A system reset, asynchronous on assertion and synchronously released, brings both registers to zero. A pin change shows at the serial output within three system clock edges.

Top module: `buffered_piso`

## Requirements
- R1: On each rising edge of the staging strobe, the staging register captures the eight parallel data pins.
- R2: While the active-low clear pin is low, all eight shift stages are zero. The clear wins over load and shift, including when it arrives in the middle of a shift sequence.
- R3: While the active-low load pin is low and the shift strobe is low, the shift register holds a copy of the staging register.
- R4: While the shift strobe is high, an asserted load leaves the shift register unchanged.
- R5: On a rising shift-strobe edge with load high and clear high, stage 0 takes the serial input and every stage n takes the old stage n-1.
- R6: The serial output is stage 7. After a parallel load, data bit 7 appears first and bit 0 appears last.
- R7: A staging-strobe rising edge while load is low and the shift strobe is low puts the newly captured pin data into the shift register in that same update.
- R8: If clear and load are asserted together and then released in the same step, the shift register is left all zeros.
- R9: Without clear, an active load or a shift-strobe rising edge, the shift register holds. This covers a staging-strobe edge while load is high, and a shift-strobe edge while load is low.
- R10: System reset zeros the staging register and the shift register. A pin change reaches the serial output within three system clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| shift_strb | input | 1 | External shift strobe, rising edge active |
| stage_strb | input | 1 | External staging strobe, rising edge active |
| load_n | input | 1 | Parallel load request, active low |
| clear_n | input | 1 | Shift register clear, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data for the staging register |
| ser_out | output | 1 | Serial data from stage 7 |

## Verification
The assertions assume that every pin is quasi-static relative to the system clock. Each pin level must last long enough for both synchronizers to settle, and all pins that change together must reach the synchronized side in the same cycle. The stimulus meets this by changing pins only on a falling system edge and holding each pin combination for four system cycles. Strobe pulses are therefore never shorter than the synchronizer depth. The assertions also assume that clear and load are released together in the invalid combined case, and the bench releases them in the same step.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned DATA_W     = 8;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_LOAD  = 2'd2,
    OP_SHIFT = 2'd3
  } shift_op_e;
endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/piso_pin_sync.sv
module piso_pin_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = din;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R10: a detected edge is a single-cycle pulse
  a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/piso_shift_core.sv
module piso_shift_core
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  input  logic             st_rise,
  input  logic             sh_lvl,
  input  logic             sh_rise,
  input  logic             load_n,
  input  logic             clear_n,
  output logic             ser_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] store_q, store_d;
  logic [WIDTH-1:0] sh_q, sh_d;
  logic [WIDTH-1:0] load_src;
  logic             store_en;
  logic             sh_en;
  shift_op_e        op;

  // staging register
  always_comb begin
    store_en = st_rise;
    store_d  = par_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        store_q <= '0;
    else if (store_en) store_q <= store_d;
  end

  // operation select: clear > load (strobe low only) > shift > hold
  always_comb begin
    if (!clear_n)                op = OP_CLEAR;
    else if (!load_n && !sh_lvl) op = OP_LOAD;
    else if (load_n && sh_rise)  op = OP_SHIFT;
    else                         op = OP_HOLD;
  end

  // a same-cycle staging capture flows straight through
  always_comb load_src = st_rise ? par_i : store_q;

  always_comb begin
    sh_en = 1'b1;
    sh_d  = sh_q;
    unique case (op)
      OP_CLEAR: sh_d = '0;
      OP_LOAD:  sh_d = load_src;
      OP_SHIFT: sh_d = {sh_q[MSB-1:0], ser_i};
      default:  sh_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign ser_o = sh_q[MSB];

  a_r1_store_capture: assert property (@(posedge clk) disable iff (!rst_n)
    st_rise |=> store_q == $past(par_i));

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> sh_q == '0);

  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n && !sh_lvl && !st_rise) |=> sh_q == $past(store_q));

  a_r4_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && sh_lvl && !sh_rise) |=> $stable(sh_q));

  a_r5_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && sh_rise) |=>
      sh_q == {$past(sh_q[MSB-1:0]), $past(ser_i)});

  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n && !sh_lvl && st_rise) |=> sh_q == $past(par_i));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !sh_rise) |=> $stable(sh_q));
endmodule

// File: rtl/buffered_piso.sv
module buffered_piso #(
  parameter int unsigned WIDTH       = piso_pkg::DATA_W,
  parameter int unsigned SYNC_STAGES = piso_pkg::SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_strb,
  input  logic             stage_strb,
  input  logic             load_n,
  input  logic             clear_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int unsigned BUS_W = WIDTH + 5;

  logic             srst_n;
  logic [BUS_W-1:0] pins_raw, pins_s;
  logic             sh_s, st_s, ld_s, clr_s, ser_s;
  logic [WIDTH-1:0] par_s;
  logic             sh_rise, st_rise;

  piso_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(srst_n));

  // all pins share one synchronizer so they stay aligned
  assign pins_raw = {par_in, ser_in, clear_n, load_n, stage_strb, shift_strb};

  piso_pin_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .din(pins_raw), .dout(pins_s));

  assign {par_s, ser_s, clr_s, ld_s, st_s, sh_s} = pins_s;

  piso_edge u_sh_edge (.clk(clk), .rst_n(srst_n), .lvl(sh_s), .rise(sh_rise));
  piso_edge u_st_edge (.clk(clk), .rst_n(srst_n), .lvl(st_s), .rise(st_rise));

  piso_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(srst_n), .par_i(par_s), .ser_i(ser_s),
    .st_rise(st_rise), .sh_lvl(sh_s), .sh_rise(sh_rise),
    .load_n(ld_s), .clear_n(clr_s), .ser_o(ser_out));
endmodule

// File: tb/buffered_piso_bench.sv
module buffered_piso_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       p_sh = 1'b0, p_st = 1'b0, p_ld = 1'b1, p_clr = 1'b1, p_ser = 1'b0;
  logic [7:0] p_par = 8'h00;
  logic       ser_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_store = 8'h00;
  logic [7:0] m_sh    = 8'h00;

  always #2 clk = ~clk;

  buffered_piso u_buffered_piso (
    .clk(clk), .rst_n(rst_n), .shift_strb(p_sh), .stage_strb(p_st),
    .load_n(p_ld), .clear_n(p_clr), .ser_in(p_ser), .par_in(p_par),
    .ser_out(ser_out));

  // vector fields: {stage, shift, load_n, clear_n, ser} then par
  localparam int NV = 26;
  localparam logic [12:0] VEC [NV] = '{
    {5'b00110, 8'hA5}, {5'b10110, 8'hA5}, {5'b00110, 8'h3C}, {5'b00010, 8'h3C},
    {5'b00111, 8'h3C}, {5'b01111, 8'h3C}, {5'b00110, 8'h3C}, {5'b01110, 8'h3C},
    {5'b00111, 8'h3C}, {5'b01111, 8'h3C}, {5'b00110, 8'h3C}, {5'b01010, 8'h3C},
    {5'b01110, 8'h3C}, {5'b00110, 8'h3C}, {5'b00010, 8'h3C}, {5'b10010, 8'hC3},
    {5'b00110, 8'hC3}, {5'b01111, 8'hC3}, {5'b00111, 8'hC3}, {5'b01111, 8'hC3},
    {5'b10110, 8'h5A}, {5'b00110, 8'h5A}, {5'b01101, 8'h00}, {5'b00111, 8'h00},
    {5'b01111, 8'h00}, {5'b00110, 8'h00}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: ser_out actual=%b expected=%b", req, got, exp);
    end
  endtask

  // drive one pin combination, advance the reference, let it settle
  task automatic apply(input logic [12:0] v);
    logic st_r, sh_r, st, sh, ld, clr, ser;
    logic [7:0] par;
    {st, sh, ld, clr, ser} = v[12:8];
    par  = v[7:0];
    st_r = st & ~p_st;
    sh_r = sh & ~p_sh;
    if (!clr)               m_sh = 8'h00;
    else if (!ld && !sh)    m_sh = st_r ? par : m_store;
    else if (ld && sh_r)    m_sh = {m_sh[6:0], ser};
    if (st_r) m_store = par;
    {p_st, p_sh, p_ld, p_clr, p_ser} = v[12:8];
    p_par = par;
    repeat (4) @(negedge clk);
  endtask

  task automatic set(input logic st, input logic sh, input logic ld,
                     input logic clr, input logic ser, input logic [7:0] par);
    apply({st, sh, ld, clr, ser, par});
  endtask

  task automatic stage_word(input logic [7:0] w);
    set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, w);
    set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, w);
  endtask

  task automatic load_pulse();
    set(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, p_par);
    set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, p_par);
  endtask

  task automatic shift_bit(input logic b);
    set(1'b0, 1'b1, 1'b1, 1'b1, b, p_par);
    set(1'b0, 1'b0, 1'b1, 1'b1, b, p_par);
  endtask

  // R6: stage 7 first, then each shift exposes the next lower stage
  task automatic readout(input logic [7:0] exp, input string req);
    for (int i = 7; i >= 0; i--) begin
      chk(ser_out, exp[i], req);
      shift_bit(1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10: watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R10: reset state, including a zeroed staging register
    chk(ser_out, 1'b0, "R10");
    load_pulse();
    readout(8'h00, "R10");

    // vector walk against the reference model
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk(ser_out, m_sh[7], "R6");
    end

    // R1 / R3: stage a word, load it, read it out MSB first
    stage_word(8'h96);
    set(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk(ser_out, 1'b1, "R3");
    set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    readout(8'h96, "R1");

    // R5: serial stream, first bit ends in stage 7
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    shift_bit(1'b0); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b0);
    readout(8'b1011_0010, "R5");

    // R4 / R9: load with strobe high is blocked; edge with load low does not shift
    stage_word(8'h5A);
    load_pulse();
    stage_word(8'hF0);
    set(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hF0);
    chk(ser_out, 1'b0, "R9");
    set(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hF0);
    set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hF0);
    readout(8'h5A, "R4");

    // R9: staging edge while load is high leaves the shift register alone
    stage_word(8'hC3);
    load_pulse();
    stage_word(8'h3C);
    readout(8'hC3, "R9");

    // R7: staging capture during an active load passes through
    stage_word(8'h11);
    set(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
    set(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE7);
    set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hE7);
    readout(8'hE7, "R7");

    // R8: clear and load together, released together
    stage_word(8'hFF);
    load_pulse();
    set(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
    readout(8'h00, "R8");

    // R2: clear in the middle of shifting
    load_pulse();
    shift_bit(1'b1); shift_bit(1'b1);
    set(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
    set(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
    chk(ser_out, 1'b0, "R2");
    set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
    readout(8'h00, "R2");

    summary();
    $finish;
  end
endmodule